// File: doc/BRIEF.md
# Serial ADC Control-Byte Framer

This block is the device-side serial front end of a four-channel, 10-bit serial converter running from an externally supplied bit clock. It oversamples the chip-select, serial clock and serial data pins on the system clock. While selected and idle, it waits for the first high data bit, which is the start bit. It then gathers that bit and the seven bits after it into a control byte. On the serial-clock falling edge after the last control bit it starts a conversion, latches the sample presented on `sample`, and shifts the 10-bit result out, most significant bit first.

The receive and transmit sides run independently. A new control byte may therefore begin while the last few result bits are still leaving, so conversions can follow each other every 15 serial clocks with select held low. Deselecting the block in mid-conversion abandons the conversion. After reset a hold-off interval, counted in system clocks, keeps the framer from accepting a start bit.

Top module: `sadc_framer`

## Requirements
- R1: While selected (`cs_n` low) and ready, the first 1 sampled on `din` at a rising `sclk` edge is the start bit. That bit and the next seven rising-edge samples form the control byte, sent MSB first: start, channel[2:0], unipolar, single-ended, power-down[1:0].
- R2: While `cs_n` is high, `sclk` edges are ignored. A falling edge on `cs_n` by itself starts nothing.
- R3: On the `sclk` falling edge after the eighth control bit, `conv_start` pulses for exactly one system clock, `sample` is latched, and `chan`, `unipolar`, `single_ended` and `pd` take the received fields.
- R4: `dout` is 0 for the falling edge that starts the conversion. The next ten falling edges drive the result from bit 9 down to bit 0, and later falling edges drive 0.
- R5: A start bit is accepted only from the first rising edge after result bit 3 has been driven. A 1 on `din` before that point is ignored. This allows one conversion every 15 `sclk` periods with `cs_n` held low.
- R6: A rising edge on `cs_n` abandons any control byte or conversion in progress. `dout` returns to 0, `strobe` goes high, and the next 1 after reselection is a start bit.
- R7: After reset, `dout` is 0 until a conversion has started.
- R8: For `HOLD_CYC` system clocks after reset, start bits are ignored and `strobe` stays high.
- R9: With `cs_n` low, 16 consecutive zero bits on `din` always leave the framer ready, so the next 1 is a start bit.
- R10: `strobe` is high exactly when a start bit would be accepted (or during hold-off). It falls the cycle after a start bit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial bit clock from the host |
| din | input | 1 | Serial control data, sampled on rising `sclk` |
| sample | input | 10 | Converter value latched at conversion start |
| dout | output | 1 | Serial result, changes after falling `sclk` |
| strobe | output | 1 | High when ready for a start bit |
| conv_start | output | 1 | One-cycle pulse at conversion start |
| chan | output | 3 | Latched channel select |
| unipolar | output | 1 | Latched unipolar/bipolar selection |
| single_ended | output | 1 | Latched single-ended/differential selection |
| pd | output | 2 | Latched power-down field |

## Verification
A receiver that has slipped a bit, or that armed too early, shows up at the ports within one conversion. Either `conv_start` fires on the wrong falling edge, or the latched channel fields are shifted, or `dout` carries result bits one period off. Because every result bit is compared in the 15-clock overlap, a ready point one edge early or late either swallows a start bit or accepts a stray 1, and the miscount is visible within the next frame. A transmitter that keeps state across a deselect leaks stale ones onto `dout` in the very next serial period.

// File: rtl/sadc_pkg.sv
// Shared types for the serial ADC framer.
// Assumes the control byte layout: start, channel[2:0], unipolar, single, pd[1:0].
package sadc_pkg;

    typedef struct packed {
        logic [2:0] chan;
        logic       unipolar;
        logic       single;
        logic [1:0] pd;
    } ctrl_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_WAIT  = 2'd2,
        RX_BUSY  = 2'd3
    } rx_state_t;

    localparam int CTRL_BITS = $bits(ctrl_t) + 1;

endpackage

// File: rtl/sadc_pin_sync.sv
// Synchronises the three serial pins into the system clock domain and
// produces one-cycle edge strobes. Assumes each sclk phase lasts at least
// two system clocks so that no edge is lost.
module sadc_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic din_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic selected,
    output logic desel,
    output logic din_s
);
    localparam logic [2:0] PIN_RST = 3'b010;

    logic [2:0] pipe [SYNC_STAGES];
    logic       sclk_q;
    logic       cs_q;
    logic [2:0] last;

    // Shift the pin group through the synchroniser chain together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= PIN_RST;
        end else begin
            pipe[0] <= {sclk_i, cs_n_i, din_i};
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign last = pipe[SYNC_STAGES-1];

    // Keep one more copy of clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= last[2];
            cs_q   <= last[1];
        end
    end

    assign sclk_rise = last[2] & ~sclk_q;
    assign sclk_fall = ~last[2] & sclk_q;
    assign selected  = ~last[1];
    assign desel     = last[1] & ~cs_q;
    assign din_s     = last[0];

endmodule

// File: rtl/sadc_ctrl_rx.sv
// Control-byte receiver: finds the start bit, collects the byte on rising
// sclk edges and issues the conversion start on the following falling edge.
// Assumes the transmitter reports when the next start bit may be taken.
module sadc_ctrl_rx
    import sadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  abort,
    input  logic  rise,
    input  logic  fall,
    input  logic  din,
    input  logic  tx_ready,
    output ctrl_t ctrl,
    output logic  conv_start,
    output logic  ready
);
    localparam int CW = $clog2(CTRL_BITS);
    localparam logic [CW-1:0] LAST_IDX = CW'(CTRL_BITS - 1);

    rx_state_t            state;
    logic [CTRL_BITS-1:0] shreg;
    logic [CW-1:0]        cnt;
    logic                 take_start;

    assign ready      = (state == RX_IDLE) || (state == RX_BUSY && tx_ready);
    assign take_start = ready && en && rise && din;

    // Framing state machine with abort taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            shreg      <= '0;
            cnt        <= '0;
            ctrl       <= '0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            if (abort) begin
                state <= RX_IDLE;
                cnt   <= '0;
            end else begin
                case (state)
                    RX_IDLE, RX_BUSY: begin
                        if (take_start) begin
                            shreg <= {{(CTRL_BITS-1){1'b0}}, 1'b1};
                            cnt   <= CW'(1);
                            state <= RX_SHIFT;
                        end
                    end
                    RX_SHIFT: begin
                        if (en && rise) begin
                            shreg <= {shreg[CTRL_BITS-2:0], din};
                            cnt   <= cnt + CW'(1);
                            if (cnt == LAST_IDX) state <= RX_WAIT;
                        end
                    end
                    RX_WAIT: begin
                        if (en && fall) begin
                            ctrl       <= ctrl_t'(shreg[CTRL_BITS-2:0]);
                            conv_start <= 1'b1;
                            state      <= RX_BUSY;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R10: taking a start bit withdraws readiness next cycle.
    p_start_drops_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_start && !abort) |=> !ready);

    // R3: the conversion start is a single-cycle pulse.
    p_conv_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

endmodule

// File: rtl/sadc_result_tx.sv
// Result transmitter: latches the sample at conversion start and drives it
// MSB first on falling sclk edges, then zero fill. Reports readiness for
// the next start bit once only the low bits remain.
module sadc_result_tx #(
    parameter int RES_BITS   = 10,
    parameter int READY_LEFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort,
    input  logic                en,
    input  logic                fall,
    input  logic                load,
    input  logic [RES_BITS-1:0] sample,
    output logic                dout,
    output logic                ready
);
    localparam int LW = $clog2(RES_BITS + 1);

    logic [RES_BITS-1:0] shreg;
    logic [LW-1:0]       left;

    assign ready = (left <= LW'(READY_LEFT));

    // Load, shift and clear the outgoing result.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            shreg <= '0;
            left  <= '0;
            dout  <= 1'b0;
        end else if (load) begin
            shreg <= sample;
            left  <= LW'(RES_BITS);
            dout  <= 1'b0;
        end else if (en && fall) begin
            if (left != '0) begin
                dout  <= shreg[RES_BITS-1];
                shreg <= {shreg[RES_BITS-2:0], 1'b0};
                left  <= left - LW'(1);
            end else begin
                dout <= 1'b0;
            end
        end
    end

    // R4: dout only moves on a falling edge, a load or an abort.
    p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !load && !abort) |=> $stable(dout));

    // R5: a freshly loaded result is not yet ready for overlap.
    p_not_ready_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !abort) |=> !ready);

endmodule

// File: rtl/sadc_framer.sv
// Top of the serial ADC framer: pin synchroniser, control receiver, result
// transmitter and the post-reset hold-off counter. Assumes sclk, cs_n and
// din are slow relative to clk (each sclk phase >= 2 clk periods).
module sadc_framer
    import sadc_pkg::*;
#(
    parameter int RES_BITS    = 10,
    parameter int READY_LEFT  = 3,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 1250
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                din,
    input  logic [RES_BITS-1:0] sample,
    output logic                dout,
    output logic                strobe,
    output logic                conv_start,
    output logic [2:0]          chan,
    output logic                unipolar,
    output logic                single_ended,
    output logic [1:0]          pd
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic          rise, fall, sel, desel, din_s;
    logic          holdoff;
    logic [HW-1:0] hold_cnt;
    logic          rx_ready, tx_ready;
    ctrl_t         ctrl_q;

    sadc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
        .sclk_rise(rise), .sclk_fall(fall),
        .selected(sel), .desel(desel), .din_s(din_s)
    );

    // Count out the post-reset interval during which requests are refused.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_cnt <= '0;
        else if (holdoff)    hold_cnt <= hold_cnt + HW'(1);
    end
    assign holdoff = (hold_cnt != HW'(HOLD_CYC));

    sadc_ctrl_rx u_rx (
        .clk(clk), .rst_n(rst_n),
        .en(sel & ~holdoff), .abort(desel),
        .rise(rise), .fall(fall), .din(din_s),
        .tx_ready(tx_ready & ~conv_start),
        .ctrl(ctrl_q), .conv_start(conv_start), .ready(rx_ready)
    );

    sadc_result_tx #(.RES_BITS(RES_BITS), .READY_LEFT(READY_LEFT)) u_tx (
        .clk(clk), .rst_n(rst_n), .abort(desel), .en(sel),
        .fall(fall), .load(conv_start), .sample(sample),
        .dout(dout), .ready(tx_ready)
    );

    assign strobe       = rx_ready;
    assign chan         = ctrl_q.chan;
    assign unipolar     = ctrl_q.unipolar;
    assign single_ended = ctrl_q.single;
    assign pd           = ctrl_q.pd;

    // R8: nothing converts while the hold-off interval runs.
    p_holdoff_no_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        holdoff |-> !conv_start);

    // R6: a deselect clears the output and re-arms the receiver.
    p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> (!dout && strobe));

endmodule

// File: tb/sadc_framer_test.sv
module sadc_framer_test;

    localparam int NV = 6;
    // {channel[2:0], unipolar, single, pd[1:0], sample[9:0]}
    localparam logic [16:0] VEC [NV] = '{
        {7'b000_1_1_11, 10'h2A5},
        {7'b101_0_1_00, 10'h3FF},
        {7'b111_1_0_01, 10'h001},
        {7'b010_0_0_10, 10'h200},
        {7'b011_1_1_11, 10'h155},
        {7'b100_0_0_00, 10'h0F0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic [9:0] sample = '0;
    logic       dout, strobe, conv_start, unipolar, single_ended;
    logic [2:0] chan;
    logic [1:0] pd;

    int checks = 0;
    int errors = 0;
    int conv_cnt = 0;
    logic       s_dout, s_strobe, s_uni, s_sgl;
    logic [2:0] s_chan;
    logic [1:0] s_pd;

    always #4 clk = ~clk;

    sadc_framer uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample(sample), .dout(dout), .strobe(strobe), .conv_start(conv_start),
        .chan(chan), .unipolar(unipolar), .single_ended(single_ended), .pd(pd)
    );

    always @(posedge clk) if (rst_n && conv_start) conv_cnt <= conv_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One sclk period: set din, sample outputs, then pulse sclk high.
    task automatic do_bit(input logic b);
        @(negedge clk) din = b;
        @(negedge clk);
        @(negedge clk);
        s_dout = dout; s_strobe = strobe; s_chan = chan;
        s_uni = unipolar; s_sgl = single_ended; s_pd = pd;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    // Single frame starting at bit 0; 1s on din in [ig_lo, ig_hi] after the byte.
    task automatic frame(input logic [7:0] bt, input logic [9:0] smp,
                         input int nbits, input int ig_lo, input int ig_hi);
        sample = smp;
        for (int o = 0; o < nbits; o++) begin
            logic b;
            logic e;
            b = (o < 8) ? bt[7-o] : (o >= ig_lo && o <= ig_hi);
            do_bit(b);
            e = (o >= 9 && o <= 18) ? smp[18-o] : 1'b0;
            chk("R4 dout bit", int'(s_dout), int'(e));
            if (o == 8) chk("R3 channel field", int'(s_chan), int'(bt[6:4]));
            if (o == 14 && nbits > 15) chk("R10 strobe low before ready", int'(s_strobe), 0);
            if (o == 15) chk("R5 strobe high after bit 3", int'(s_strobe), 1);
        end
    endtask

    // Back-to-back conversions from the vector table with a given period.
    task automatic run_stream(input int period);
        int total;
        int c0;
        total = NV * period + 20;
        c0 = conv_cnt;
        for (int k = 0; k < total; k++) begin
            int j;
            int o;
            logic [7:0] bt;
            logic b;
            logic e;
            j = k / period;
            o = k % period;
            b = 1'b0;
            e = 1'b0;
            if (j < NV) begin
                bt = {1'b1, VEC[j][16:10]};
                if (o == 0) sample = VEC[j][9:0];
                if (o < 8) b = bt[7-o];
            end
            do_bit(b);
            for (int d = 0; d < 2; d++) begin
                int jj;
                int oo;
                jj = j - d;
                oo = k - jj * period;
                if (jj >= 0 && jj < NV && oo >= 9 && oo <= 18) e = VEC[jj][18-oo];
            end
            chk("R4/R5 stream dout", int'(s_dout), int'(e));
            if (j < NV && o == 8) begin
                chk("R3 chan", int'(s_chan), int'(VEC[j][16:14]));
                chk("R3 unipolar", int'(s_uni), int'(VEC[j][13]));
                chk("R3 single", int'(s_sgl), int'(VEC[j][12]));
                chk("R1 pd", int'(s_pd), int'(VEC[j][11:10]));
            end
        end
        chk("R5 conversions in stream", conv_cnt - c0, NV);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: all R, actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        chk("R7 dout in reset", int'(dout), 0);
        chk("R10 strobe in reset", int'(strobe), 1);
        chk("R3 no pulse in reset", int'(conv_start), 0);
        rst_n = 1'b1;

        // R8: a full byte during hold-off is ignored.
        for (int o = 0; o < 20; o++) begin
            do_bit(o == 0 || o >= 4 && o < 8);
            chk("R7 dout zero before conversion", int'(s_dout), 0);
            chk("R8 strobe high in hold-off", int'(s_strobe), 1);
        end
        chk("R8 no conversion in hold-off", conv_cnt, 0);
        repeat (1300) @(negedge clk);

        // R2: sclk with cs_n high, then a bare cs_n fall, starts nothing.
        cs_n = 1'b1;
        for (int o = 0; o < 10; o++) do_bit(1'b1);
        chk("R2 ignored while deselected", conv_cnt, 0);
        cs_n = 1'b0;
        for (int o = 0; o < 10; o++) do_bit(1'b0);
        chk("R2 cs fall alone", conv_cnt, 0);
        chk("R2 strobe still high", int'(s_strobe), 1);

        // R1/R3/R4/R5: table streams with 15- and 16-clock framing.
        run_stream(15);
        run_stream(16);

        // R5: 1s on din before bit 3 is out are ignored.
        c0 = conv_cnt;
        frame(8'b1_001_1_1_00, 10'h2C3, 26, 8, 14);
        chk("R5 early ones ignored", conv_cnt - c0, 1);

        // R9: start bit plus 15 zeros, then a 1 is a start bit.
        c0 = conv_cnt;
        frame(8'h80, 10'h3C3, 16, -1, -1);
        do_bit(1'b1);
        chk("R9 ready after 16 zeros", int'(s_strobe), 1);
        for (int o = 0; o < 25; o++) do_bit(1'b0);
        chk("R9 second start taken", conv_cnt - c0, 2);

        // R6: deselect mid-result, then restart at once.
        c0 = conv_cnt;
        frame(8'hFF, 10'h3FF, 12, -1, -1);
        @(negedge clk) cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6 dout cleared on abort", int'(dout), 0);
        chk("R6 strobe high on abort", int'(strobe), 1);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        frame(8'b1_010_0_1_10, 10'h0AB, 25, -1, -1);
        chk("R6 restart after abort", conv_cnt - c0, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule